// File: doc/BRIEF.md
# DMA Graceful Stop and Transmit Poll Controller

This block implements the graceful-stop and polling parts of a DMA control register. Software writes a three-bit control word through a one-cycle write strobe. When the word requests a receive or transmit stop, the block emits a one-clock completion pulse for that path. The pulse comes right away if that path has no frame in flight. If a frame is in flight, the pulse waits until the frame-in-progress indication from that path drops.

A periodic poll timer makes transmit queue 0 get scanned without software kicking it. Any control write with the poll-wait bit clear restarts the timer with a full period. At each expiry the block raises a scan request, unless the control word currently asks for a transmit stop. It then re-arms. If the poll-wait bit is set at expiry, the timer stops instead. The scan request stays high until the transmit engine acknowledges it.

The poll period in clock cycles is CLK_HZ / POLL_HZ, and POLL_HZ defaults to 100 polls per second.

Top module: `dma_gsp`

## Requirements
- R1: A control write with bit 0 (receive stop) set while `rx_busy_i` is low makes `rx_stop_done_o` high in the cycle after the write is sampled.
- R2: A control write with bit 0 set while `rx_busy_i` is high produces no pulse while busy stays high. The pulse comes in the cycle after `rx_busy_i` is first sampled low.
- R3: A control write with bit 1 (transmit stop) set while `tx_busy_i` is low makes `tx_stop_done_o` high in the cycle after the write.
- R4: A control write with bit 1 set while `tx_busy_i` is high defers `tx_stop_done_o` until the cycle after `tx_busy_i` is sampled low.
- R5: Each completion pulse lasts exactly one clock. A later control write with the stop bit clear cancels a pending deferred completion, so no pulse follows when the frame ends.
- R6: A control write with bit 2 (poll wait) clear restarts the poll timer. The first expiry comes PERIOD = CLK_HZ/POLL_HZ cycles after the write edge, and any earlier countdown is discarded.
- R7: At an expiry where poll wait and transmit stop are both clear in the control word, `scan_req_o` rises. The timer then re-arms, so expiries repeat every PERIOD cycles.
- R8: At an expiry where transmit stop is set, no scan is requested, but the timer still re-arms.
- R9: At an expiry where poll wait is set, the timer stops. No further scan request occurs until a write with poll wait clear.
- R10: `scan_req_o` stays high until `scan_ack_i` is sampled high, and it clears in the following cycle.
- R11: After reset all outputs are low, the control word is zero and the poll timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control word: bit0 receive stop, bit1 transmit stop, bit2 poll wait |
| rx_busy_i | input | 1 | Receive frame in progress |
| tx_busy_i | input | 1 | Transmit frame in progress |
| scan_ack_i | input | 1 | Transmit engine accepts the scan request |
| rx_stop_done_o | output | 1 | Receive stop complete, one-clock pulse |
| tx_stop_done_o | output | 1 | Transmit stop complete, one-clock pulse |
| scan_req_o | output | 1 | Request to scan transmit queue 0 |

## Verification
Stop requests are applied in three patterns, and each one separates a different behaviour:
- An idle path shows the immediate completion.
- A busy path that later goes idle shows the deferred completion.
- A busy path whose request is withdrawn before the frame ends shows the cancel.

The poll timer is exercised in four ways:
- A plain start measures the period and the re-arm.
- A restart in mid-period shows that the old countdown is discarded.
- A run with transmit stop set shows that expiries are gated but still re-arm.
- A run with poll wait set before expiry shows that the timer halts.

A scoreboard holds the exact cycle of every expected pulse and scan rise. Any extra event, or any event in the wrong cycle, is therefore reported.

// File: rtl/dma_gsp_pkg.sv
package dma_gsp_pkg;
  localparam int CTRL_W = 3;
  localparam int NUM_PATHS = 2;

  typedef struct packed {
    logic poll_wait;
    logic tx_stop;
    logic rx_stop;
  } ctrl_t;
endpackage

// File: rtl/dma_gsp_stop_trk.sv
module dma_gsp_stop_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic stop_i,
  input  logic busy_i,
  output logic done_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (wr_i) begin
        if (stop_i && !busy_i) begin
          done_o <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          pend_q <= stop_i;   // busy: defer; stop cleared: cancel
        end
      end else if (pend_q && !busy_i) begin
        done_o <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_gsp_poll.sv
module dma_gsp_poll #(
  parameter int PERIOD = 2_000_000,
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic wait_q_i,
  input  logic tx_stop_q_i,
  input  logic ack_i,
  output logic scan_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             fire;

  assign expire = run_q && (cnt_q == '0);
  assign fire   = expire && !restart_i && !wait_q_i && !tx_stop_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (restart_i) begin
      run_q <= 1'b1;
      cnt_q <= RELOAD;
    end else if (expire) begin
      if (wait_q_i) run_q <= 1'b0;
      else          cnt_q <= RELOAD;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_o <= 1'b0;
    else         scan_o <= fire | (scan_o & ~ack_i);
  end
endmodule

// File: rtl/dma_gsp.sv
module dma_gsp
  import dma_gsp_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int POLL_HZ = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              rx_busy_i,
  input  logic              tx_busy_i,
  input  logic              scan_ack_i,
  output logic              rx_stop_done_o,
  output logic              tx_stop_done_o,
  output logic              scan_req_o
);
  localparam int PERIOD = CLK_HZ / POLL_HZ;

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic [NUM_PATHS-1:0] stop_bit;
  logic [NUM_PATHS-1:0] busy;
  logic [NUM_PATHS-1:0] done;

  assign ctrl_d = ctrl_t'(ctrl_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_d;
  end

  assign stop_bit = {ctrl_d.tx_stop, ctrl_d.rx_stop};
  assign busy     = {tx_busy_i, rx_busy_i};

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    dma_gsp_stop_trk u_trk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (ctrl_wr_i),
      .stop_i (stop_bit[p]),
      .busy_i (busy[p]),
      .done_o (done[p])
    );
  end

  assign rx_stop_done_o = done[0];
  assign tx_stop_done_o = done[1];

  dma_gsp_poll #(.PERIOD(PERIOD)) u_poll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (ctrl_wr_i && !ctrl_d.poll_wait),
    .wait_q_i    (ctrl_q.poll_wait),
    .tx_stop_q_i (ctrl_q.tx_stop),
    .ack_i       (scan_ack_i),
    .scan_o      (scan_req_o)
  );
endmodule

// File: rtl/dma_gsp_chk.sv
module dma_gsp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_wr_i,
  input logic [2:0] ctrl_wdata_i,
  input logic       rx_busy_i,
  input logic       tx_busy_i,
  input logic       scan_ack_i,
  input logic       rx_stop_done_o,
  input logic       tx_stop_done_o,
  input logic       scan_req_o
);
  // R1
  rx_idle_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_wdata_i[0] && !rx_busy_i |=> rx_stop_done_o);
  // R2
  rx_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_busy_i |=> !rx_stop_done_o);
  // R3
  tx_idle_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_wdata_i[1] && !tx_busy_i |=> tx_stop_done_o);
  // R4
  tx_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> !tx_stop_done_o);
  // R10
  scan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_req_o && !scan_ack_i |=> scan_req_o);
endmodule

bind dma_gsp dma_gsp_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctrl_wr_i      (ctrl_wr_i),
  .ctrl_wdata_i   (ctrl_wdata_i),
  .rx_busy_i      (rx_busy_i),
  .tx_busy_i      (tx_busy_i),
  .scan_ack_i     (scan_ack_i),
  .rx_stop_done_o (rx_stop_done_o),
  .tx_stop_done_o (tx_stop_done_o),
  .scan_req_o     (scan_req_o)
);

// File: tb/dma_gsp_tb.sv
module dma_gsp_tb;
  localparam int CLK_HZ = 2000;
  localparam int POLL_HZ = 100;
  localparam int P = CLK_HZ / POLL_HZ;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [2:0] ctrl_wdata = '0;
  logic       rx_busy = 1'b0;
  logic       tx_busy = 1'b0;
  logic       scan_ack = 1'b0;
  logic       rx_done;
  logic       tx_done;
  logic       scan_req;

  int   cyc = 0;
  int   vectors = 0;
  int   errors = 0;
  logic ack_en = 1'b1;
  logic prev_scan = 1'b0;
  logic pend_rx = 1'b0;
  logic pend_tx = 1'b0;
  exp_t q[$];
  string kname[3] = '{"rx_stop_done", "tx_stop_done", "scan_req rise"};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_gsp #(.CLK_HZ(CLK_HZ), .POLL_HZ(POLL_HZ)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ctrl_wr_i      (ctrl_wr),
    .ctrl_wdata_i   (ctrl_wdata),
    .rx_busy_i      (rx_busy),
    .tx_busy_i      (tx_busy),
    .scan_ack_i     (scan_ack),
    .rx_stop_done_o (rx_done),
    .tx_stop_done_o (tx_done),
    .scan_req_o     (scan_req)
  );

  always @(negedge clk) scan_ack <= ack_en && scan_req;

  task automatic chk(input string req, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, got, exp);
    end
  endtask

  task automatic sb_check(input int kind);
    vectors++;
    if (q.size() > 0 && q[0].kind == kind && q[0].cyc == cyc) begin
      void'(q.pop_front());
    end else begin
      errors++;
      if (q.size() > 0)
        $display("FAIL %s: got %s at cycle %0d expected %s at cycle %0d",
                 q[0].req, kname[kind], cyc, kname[q[0].kind], q[0].cyc);
      else
        $display("FAIL unexpected: got %s at cycle %0d expected none", kname[kind], cyc);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_done) sb_check(0);
      if (tx_done) sb_check(1);
      if (scan_req && !prev_scan) sb_check(2);
      prev_scan = scan_req;
    end
  end

  task automatic push(input int kind, input int c, input string req);
    exp_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    q.push_back(e);
  endtask

  // driver: one control write, pushes expected stop completions
  task automatic wr(input logic rx, input logic tx, input logic wt, output int c);
    @(negedge clk);
    c = cyc;
    ctrl_wr = 1'b1;
    ctrl_wdata = {wt, tx, rx};
    if (rx && !rx_busy) push(0, c + 1, "R1");
    pend_rx = rx && rx_busy;
    if (tx && !tx_busy) push(1, c + 1, "R3");
    pend_tx = tx && tx_busy;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic drop_rx_busy();
    @(negedge clk);
    rx_busy = 1'b0;
    if (pend_rx) push(0, cyc + 1, "R2");
    pend_rx = 1'b0;
  endtask

  task automatic drop_tx_busy();
    @(negedge clk);
    tx_busy = 1'b0;
    if (pend_tx) push(1, cyc + 1, "R4");
    pend_tx = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c, c2;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", rx_done, 1'b0);
    chk("R11", tx_done, 1'b0);
    chk("R11", scan_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    wait_until(cyc + 2 * P);
    chk("R11 timer stopped", scan_req, 1'b0);

    // R1 idle receive stop, R5 one-clock pulse
    wr(1'b1, 1'b0, 1'b1, c);
    chk("R1", rx_done, 1'b1);
    @(negedge clk);
    chk("R5 pulse width", rx_done, 1'b0);

    // R2 deferred receive stop
    rx_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b1, c);
    repeat (4) @(negedge clk);
    chk("R2 held while busy", rx_done, 1'b0);
    drop_rx_busy();
    @(negedge clk);
    chk("R2", rx_done, 1'b1);
    repeat (3) @(negedge clk);

    // R3 idle transmit stop
    wr(1'b0, 1'b1, 1'b1, c);
    chk("R3", tx_done, 1'b1);
    repeat (2) @(negedge clk);

    // R4 deferred transmit stop
    tx_busy = 1'b1;
    wr(1'b0, 1'b1, 1'b1, c);
    repeat (3) @(negedge clk);
    chk("R4 held while busy", tx_done, 1'b0);
    drop_tx_busy();
    @(negedge clk);
    chk("R4", tx_done, 1'b1);
    repeat (3) @(negedge clk);

    // R5 cancel of a pending transmit stop
    tx_busy = 1'b1;
    wr(1'b0, 1'b1, 1'b1, c);
    repeat (2) @(negedge clk);
    wr(1'b0, 1'b0, 1'b1, c);
    drop_tx_busy();
    repeat (4) @(negedge clk);
    chk("R5 cancel", tx_done, 1'b0);

    // R6/R7 start, period, re-arm; R10 hold until ack
    @(posedge clk); ack_en = 1'b0;
    wr(1'b0, 1'b0, 1'b0, c);
    push(2, c + 1 + P, "R6");
    push(2, c + 1 + 2 * P, "R7");
    wait_until(c + P);
    chk("R6 not early", scan_req, 1'b0);
    wait_until(c + P + 5);
    chk("R10 held", scan_req, 1'b1);
    @(posedge clk); ack_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 cleared", scan_req, 1'b0);
    wait_until(c + 2 * P + 4);
    wr(1'b0, 1'b0, 1'b1, c2);
    wait_until(c + 4 * P + 5);
    chk("R9", scan_req, 1'b0);

    // R6 restart in mid-period
    wr(1'b0, 1'b0, 1'b0, c);
    wait_until(c + 10);
    wr(1'b0, 1'b0, 1'b0, c2);
    push(2, c2 + 1 + P, "R6 restart");
    wait_until(c2 + P + 3);
    wr(1'b0, 1'b0, 1'b1, c);
    wait_until(c2 + 3 * P + 5);
    chk("R9", scan_req, 1'b0);

    // R8 transmit stop gates scans
    wr(1'b0, 1'b1, 1'b0, c);
    wait_until(c + 2 * P + 5);
    chk("R8", scan_req, 1'b0);
    wr(1'b0, 1'b0, 1'b1, c);
    wait_until(c + 2 * P + 3);

    // R9 poll wait set before expiry halts the timer
    wr(1'b0, 1'b0, 1'b0, c);
    repeat (5) @(negedge clk);
    wr(1'b0, 1'b0, 1'b1, c2);
    wait_until(c + 3 * P + 5);
    chk("R9 halted", scan_req, 1'b0);

    foreach (q[i]) begin
      errors++;
      $display("FAIL %s: got nothing expected %s at cycle %0d", q[i].req, kname[q[i].kind], q[i].cyc);
    end
    summary();
    $finish;
  end
endmodule